// File: doc/BRIEF.md
# I2C Serial EEPROM Read Target

This block is a two-wire bus target that serves a 256-byte array the way a small serial EEPROM does. SCL and SDA arrive from the pins, are resynchronised into the system clock domain, and are watched for start, repeated-start and stop conditions. The first byte after a start is a header holding a four-bit device type code, three strap bits and a direction bit. When it matches, the target acknowledges by pulling SDA low through an open-drain enable and then either takes a word address and data bytes, or returns data bytes.

One address register persists across transactions. A read header on its own returns the byte the register points at. A write header followed only by a word address and then a repeated start loads the register, which is the usual way to do a random read. The register steps by one after every byte moved in either direction, so a read continues through memory for as long as the master acknowledges, and it rolls from the top location back to zero. Data bytes that follow a word address are stored one at a time, each at the current location.

Top module: `ee_target`

## Requirements
- R1: A header byte equal to {4'b1010, strap_i[2:0], rw} is acknowledged by driving sda_oe_o high during the ninth clock. rw = 1 selects a read and rw = 0 selects a write.
- R2: A header that does not match gets no acknowledge. SDA stays released for the rest of the transaction, and later bytes up to the next start condition have no effect on the address register or the array.
- R3: In a write, the byte after the header is acknowledged and becomes the new value of the address register.
- R4: Each data byte after the word address is acknowledged and stored at the current location, after which the address register advances by one.
- R5: A read header with no word address phase returns the byte at the address register, MSB first, and the register advances by one once the byte has been sent.
- R6: A write header and word address, followed by a repeated start and a read header, return the byte at the loaded address.
- R7: While the master acknowledges each returned byte, the target keeps sending the byte at the next location.
- R8: Advancing the address register from 255 gives 0. This holds for reads and for writes.
- R9: After the master does not acknowledge a returned byte, the target releases SDA and stays released until the next start.
- R10: The target changes sda_oe_o only while SCL is low.
- R11: Reset sets the address register to 0, returns the bus logic to idle and releases SDA. The array contents are kept.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low synchronous reset |
| strap_i | input | 3 | Board strap bits compared against header bits 3..1 |
| scl_i | input | 1 | Serial clock from the bus |
| sda_i | input | 1 | Serial data as seen on the bus |
| sda_oe_o | output | 1 | High pulls SDA low (open-drain enable) |

## Verification
Every 7-bit header value is sent with the strap bits fixed. Only the matching value may be acknowledged, and each mismatch is followed by a stray byte to show that it is ignored. The whole array is written with an arithmetic pattern in one long burst, so the final wrap of the write address is exercised. Reads then come in three forms: a bare current read, a random read through a dummy write, and a sequential burst that crosses 255 to 0. Each form separates a wrong data path from a wrong register update. A reset in the middle of traffic followed by a bare read shows that the register was cleared while the stored bytes were kept.

// File: rtl/ee_target_pkg.sv
package ee_target_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HDR,
    ST_WADDR,
    ST_WDATA,
    ST_ACK,
    ST_RDATA,
    ST_RACK
  } bus_st_e;

  // Header match: upper seven bits against type code and strap bits.
  function automatic logic hdr_hit(input logic [6:0] hdr7,
                                   input logic [3:0] code,
                                   input logic [2:0] strap);
    return hdr7 == {code, strap};
  endfunction

endpackage

// File: rtl/ee_bus_sync.sv
module ee_bus_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  localparam int PW = STAGES + 1;

  logic [PW-1:0] scl_pipe, sda_pipe;
  logic scl_q, sda_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
    end else begin
      scl_pipe <= {scl_pipe[PW-2:0], scl_i};
      sda_pipe <= {sda_pipe[PW-2:0], sda_i};
    end
  end

  assign scl_s = scl_pipe[STAGES-1];
  assign scl_q = scl_pipe[STAGES];
  assign sda_s = sda_pipe[STAGES-1];
  assign sda_q = sda_pipe[STAGES];

  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_det = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/ee_addr_ctr.sv
module ee_addr_ctr #(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] load_val,
  input  logic          inc,
  output logic [AW-1:0] cnt
);
  // Next location, rolling over from the top back to zero.
  function automatic logic [AW-1:0] bump(input logic [AW-1:0] a);
    return a + AW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n)     cnt <= '0;
    else if (load)  cnt <= load_val;
    else if (inc)   cnt <= bump(cnt);
  end
endmodule

// File: rtl/ee_byte_mem.sv
module ee_byte_mem #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/ee_target.sv
module ee_target
  import ee_target_pkg::*;
#(
  parameter int         AW        = 8,
  parameter logic [3:0] TYPE_CODE = 4'b1010
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] strap_i,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe_o
);
  localparam int BYTE_W = 8;
  localparam int BC_W   = $clog2(BYTE_W + 1);
  localparam logic [BC_W-1:0] BC_FULL = BC_W'(BYTE_W);

  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;

  ee_bus_sync #(.STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  bus_st_e            state_q, ack_next_q;
  logic [BC_W-1:0]    bit_q;
  logic [BYTE_W-1:0]  rx_q, tx_q;
  logic               sda_oe_q, more_q;
  logic [AW-1:0]      cnt;
  logic [BYTE_W-1:0]  rd_byte;

  // Named internal events, shared with the checker.
  logic byte_end, hdr_done, hdr_match, cnt_load, mem_we, tx_done, cnt_inc, bus_idle;
  logic [AW-1:0] addr_load_val;

  assign byte_end      = scl_fall && (bit_q == BC_FULL) && !start_det && !stop_det;
  assign hdr_done      = (state_q == ST_HDR) && byte_end;
  assign hdr_match     = hdr_hit(rx_q[7:1], TYPE_CODE, strap_i);
  assign cnt_load      = (state_q == ST_WADDR) && byte_end;
  assign mem_we        = (state_q == ST_WDATA) && byte_end;
  assign tx_done       = (state_q == ST_RDATA) && byte_end;
  assign cnt_inc       = mem_we || tx_done;
  assign bus_idle      = (state_q == ST_IDLE);
  assign addr_load_val = rx_q[AW-1:0];

  ee_addr_ctr #(.AW(AW)) u_ctr (
    .clk(clk), .rst_n(rst_n), .load(cnt_load), .load_val(addr_load_val),
    .inc(cnt_inc), .cnt(cnt)
  );

  ee_byte_mem #(.AW(AW), .DW(BYTE_W)) u_mem (
    .clk(clk), .we(mem_we), .waddr(cnt), .wdata(rx_q),
    .raddr(cnt), .rdata(rd_byte)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      ack_next_q <= ST_IDLE;
      bit_q      <= '0;
      rx_q       <= '0;
      tx_q       <= '0;
      sda_oe_q   <= 1'b0;
      more_q     <= 1'b0;
    end else if (start_det) begin
      state_q  <= ST_HDR;
      bit_q    <= '0;
      sda_oe_q <= 1'b0;
    end else if (stop_det) begin
      state_q  <= ST_IDLE;
      sda_oe_q <= 1'b0;
    end else begin
      case (state_q)
        ST_HDR, ST_WADDR, ST_WDATA: begin
          if (scl_rise && bit_q != BC_FULL) begin
            rx_q  <= {rx_q[BYTE_W-2:0], sda_s};
            bit_q <= bit_q + BC_W'(1);
          end
          if (byte_end) begin
            bit_q <= '0;
            if (state_q == ST_HDR && !hdr_match) begin
              state_q <= ST_IDLE;
            end else begin
              sda_oe_q <= 1'b1;
              state_q  <= ST_ACK;
              if (state_q == ST_HDR) ack_next_q <= rx_q[0] ? ST_RDATA : ST_WADDR;
              else                   ack_next_q <= ST_WDATA;
            end
          end
        end
        ST_ACK: begin
          if (scl_fall) begin
            bit_q   <= '0;
            state_q <= ack_next_q;
            if (ack_next_q == ST_RDATA) begin
              tx_q     <= rd_byte;
              sda_oe_q <= ~rd_byte[BYTE_W-1];
            end else begin
              sda_oe_q <= 1'b0;
            end
          end
        end
        ST_RDATA: begin
          if (scl_rise) bit_q <= bit_q + BC_W'(1);
          if (scl_fall) begin
            if (bit_q == BC_FULL) begin
              sda_oe_q <= 1'b0;
              state_q  <= ST_RACK;
            end else begin
              sda_oe_q <= ~tx_q[BYTE_W-2];
              tx_q     <= {tx_q[BYTE_W-2:0], 1'b0};
            end
          end
        end
        ST_RACK: begin
          if (scl_rise) more_q <= ~sda_s;
          if (scl_fall) begin
            if (more_q) begin
              tx_q     <= rd_byte;
              sda_oe_q <= ~rd_byte[BYTE_W-1];
              bit_q    <= '0;
              state_q  <= ST_RDATA;
            end else begin
              state_q <= ST_IDLE;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign sda_oe_o = sda_oe_q;
endmodule

// File: rtl/ee_target_chk.sv
module ee_target_chk #(
  parameter int AW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          scl_s,
  input logic          sda_oe,
  input logic          hdr_done,
  input logic          hdr_match,
  input logic          cnt_load,
  input logic [AW-1:0] load_val,
  input logic          cnt_inc,
  input logic          mem_we,
  input logic          bus_idle,
  input logic [AW-1:0] cnt
);
  p_ack_on_match_r1: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_done && hdr_match |=> sda_oe);

  p_silent_on_miss_r2: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_done && !hdr_match |=> !sda_oe && bus_idle);

  p_addr_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_load |=> cnt == $past(load_val));

  p_write_ack_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> sda_oe);

  // Single step with rollover at the top location (R5, R7).
  p_step_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_inc |=> cnt == AW'($past(cnt) + 1'b1));

  p_idle_released_r9: assert property (@(posedge clk) disable iff (!rst_n)
    bus_idle |-> !sda_oe);

  p_scl_low_change_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !scl_s);
endmodule

bind ee_target ee_target_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_oe(sda_oe_o),
  .hdr_done(hdr_done), .hdr_match(hdr_match), .cnt_load(cnt_load),
  .load_val(addr_load_val), .cnt_inc(cnt_inc), .mem_we(mem_we),
  .bus_idle(bus_idle), .cnt(cnt)
);

// File: tb/test_ee_target.sv
`timescale 1ns/1ps
module test_ee_target;
  localparam int Q = 4;
  localparam logic [2:0] STRAP = 3'b101;
  localparam logic [7:0] HDR_W = {4'b1010, STRAP, 1'b0};
  localparam logic [7:0] HDR_R = {4'b1010, STRAP, 1'b1};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic m_low = 1'b0;
  logic sda_oe;
  wire  sda_line = ~(m_low | sda_oe);

  int n_chk = 0;
  int n_err = 0;
  int r10_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  ee_target i_ee_target (
    .clk(clk), .rst_n(rst_n), .strap_i(STRAP),
    .scl_i(scl), .sda_i(sda_line), .sda_oe_o(sda_oe)
  );

  function automatic logic [7:0] pat(input int a);
    return 8'((a * 37 + 11) & 255) ^ 8'h5A;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wq(input int n = 1);
    repeat (n * Q) @(negedge clk);
  endtask

  // R10 monitor: the target output must not move while SCL is high.
  logic oe_prev = 1'b0;
  always @(negedge clk) begin
    if (rst_n && scl && sda_oe != oe_prev) r10_bad++;
    oe_prev <= sda_oe;
  end

  task automatic bus_start;
    m_low = 1'b0; wq(); scl = 1'b1; wq(); m_low = 1'b1; wq(); scl = 1'b0; wq();
  endtask

  task automatic bus_rstart;
    m_low = 1'b0; wq(); scl = 1'b1; wq(); m_low = 1'b1; wq(); scl = 1'b0; wq();
  endtask

  task automatic bus_stop;
    m_low = 1'b1; wq(); scl = 1'b1; wq(); m_low = 1'b0; wq();
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      m_low = ~b[i]; wq(); scl = 1'b1; wq(2); scl = 1'b0; wq();
    end
    m_low = 1'b0; wq(); scl = 1'b1; wq(); ack = ~sda_line; wq(); scl = 1'b0; wq();
  endtask

  task automatic recv_byte(output logic [7:0] b, input bit ack);
    m_low = 1'b0;
    for (int i = 7; i >= 0; i--) begin
      wq(); scl = 1'b1; wq(); b[i] = sda_line; wq(); scl = 1'b0; wq();
    end
    m_low = ack; wq(); scl = 1'b1; wq(2); scl = 1'b0; wq(); m_low = 1'b0;
  endtask

  task automatic set_addr(input logic [7:0] a, input string req);
    bit ack;
    bus_start;
    send_byte(HDR_W, ack); check(ack, {req, " header ack"}, ack, 1);
    send_byte(a, ack);     check(ack, {req, " word address ack (R3)"}, ack, 1);
  endtask

  task automatic cur_read(input logic [7:0] exp, input string req);
    bit ack;
    logic [7:0] d;
    bus_start;
    send_byte(HDR_R, ack); check(ack, {req, " read header ack (R1)"}, ack, 1);
    recv_byte(d, 1'b0);
    check(d == exp, req, d, exp);
    bus_stop;
  endtask

  task automatic rnd_read(input logic [7:0] a, input logic [7:0] exp, input string req);
    bit ack;
    logic [7:0] d;
    set_addr(a, req);
    bus_rstart;
    send_byte(HDR_R, ack); check(ack, {req, " read header ack"}, ack, 1);
    recv_byte(d, 1'b0);
    check(d == exp, req, d, exp);
    bus_stop;
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    bit ack;
    logic [7:0] d;
    repeat (10) @(negedge clk);
    check(sda_oe == 1'b0, "R11 released in reset", sda_oe, 0);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);
    check(sda_oe == 1'b0, "R11 released after reset", sda_oe, 0);

    // Fill the whole array in one burst; write address wraps to 0 (R4, R8).
    set_addr(8'h00, "R3 fill");
    for (int a = 0; a < 256; a++) begin
      send_byte(pat(a), ack);
      check(ack, "R4 data ack", ack, 1);
    end
    bus_stop;
    cur_read(pat(0), "R8 write wrap then current read");

    // Reset mid-traffic clears the address register only (R11).
    set_addr(8'h40, "R11 preload");
    bus_stop;
    rst_n = 1'b0; repeat (5) @(negedge clk); rst_n = 1'b1; repeat (5) @(negedge clk);
    cur_read(pat(0), "R11 counter cleared, array kept");
    cur_read(pat(1), "R5 current read advances");

    rnd_read(8'h37, pat(8'h37), "R6 random read");
    cur_read(pat(8'h38), "R5 current after random");

    // Sequential read across 255 -> 0 (R7, R8).
    set_addr(8'hFC, "R7 seq");
    bus_rstart;
    send_byte(HDR_R, ack); check(ack, "R7 read header ack", ack, 1);
    for (int i = 0; i < 8; i++) begin
      recv_byte(d, i != 7);
      check(d == pat((8'hFC + i) & 255), (i >= 4) ? "R8 seq wrap" : "R7 seq", d, pat((8'hFC + i) & 255));
    end
    repeat (2) @(negedge clk);
    check(sda_oe == 1'b0, "R9 released after nack", sda_oe, 0);
    wq(); scl = 1'b1; wq(); scl = 1'b0; wq();
    check(sda_oe == 1'b0, "R9 stays released", sda_oe, 0);
    bus_stop;

    // Exhaustive header sweep, write direction (R1, R2).
    for (int h = 0; h < 128; h++) begin
      bus_start;
      send_byte({7'(h), 1'b0}, ack);
      check(ack == (h == 7'h55), "R1/R2 header sweep", ack, (h == 7'h55));
      if (h != 7'h55) begin
        send_byte(8'h99, ack);
        check(!ack, "R2 stray byte ignored", ack, 0);
        send_byte(8'h10, ack);
        check(!ack, "R2 stray byte ignored", ack, 0);
      end
      bus_stop;
    end
    bus_start;
    send_byte({4'b1010, 3'b001, 1'b1}, ack);
    check(!ack, "R2 wrong strap read header", ack, 0);
    bus_stop;
    cur_read(pat(4), "R2 counter untouched by ignored traffic");

    // Single byte rewrite then read back (R4).
    set_addr(8'h10, "R4 single");
    send_byte(8'hC3, ack); check(ack, "R4 single data ack", ack, 1);
    bus_stop;
    cur_read(pat(8'h11), "R4 counter advanced after write");
    rnd_read(8'h10, 8'hC3, "R4 stored byte");

    check(r10_bad == 0, "R10 sda change while scl high", r10_bad, 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule